// File: doc/BRIEF.md
# Virtual Wire Reset Handshake Responder

This block answers warning virtual wires from the host-side controller of a serial peripheral link, on the device side. It follows three warnings: host reset, out-of-band reset and suspend. When a warning is raised, the block asks the matching upstream request queues to stop taking work and to drain. It raises the matching acknowledge wire only after those queues report that they are empty and that nothing is in flight. When the warning is lowered, the acknowledge is lowered with it. The master can then turn the drained channel off by writing the channel-enable register. Upstream requests on a channel that is disabled or quiescing are refused.

The block also drives the two boot wires. When firmware reports that booting has finished, boot-done is set and the image-integrity result is latched into boot-status. Both then hold until a G3 reset. Every change on an outgoing wire (the three acknowledges and the two boot wires) is reported once, as a one-cycle event carrying a wire number and the new level. An upstream transmit path can send these events to the master. Packet framing, CRC and the serial physical layer belong to other blocks.

Top module: `vwr_responder`

## Requirements
- R1: While `rst_n` is low, and on the clock after `g3_rst` is high, the following are all zero: every acknowledge wire, both boot wires, `ch_en` and `quiesce`. Wire changes caused by a G3 reset produce no event.
- R2: A host-reset warning (event id 0, level 1) sets `quiesce[0]` on the next clock. `host_rst_ack` rises one clock after the first clock edge, taken while draining, at which `q_empty[0]`=1 and `q_busy[0]`=0.
- R3: An out-of-band reset warning (event id 1, level 1) sets `quiesce[2]` on the next clock. `oob_rst_ack` rises one clock after the first edge at which channel 2 is empty and not busy.
- R4: A suspend warning (event id 2, level 1) quiesces channels 0, 2 and 3, but not channel 1. `sus_ack` rises one clock after the first edge at which all three of those channels are idle.
- R5: A level-0 event for a warning lowers its acknowledge and its quiesce request on the next clock. A level-1 event that arrives while the acknowledge is high lowers the acknowledge and starts the drain again.
- R6: A write with `cfg_we` loads `cfg_wdata` into `ch_en` on the next clock. Bit c enables channel c: 0 is peripheral, 1 is virtual wire, 2 is out-of-band, 3 is flash.
- R7: `up_accept[c]` equals `up_req[c]` when `ch_en[c]`=1 and `quiesce[c]`=0. Otherwise it is 0.
- R8: A `fw_boot_done` pulse sets `boot_done` and copies `fw_boot_ok` into `boot_status`. Further pulses leave both wires unchanged until a G3 reset.
- R9: Each change of an outgoing wire produces exactly one cycle with `tx_valid`=1. That cycle carries `tx_id` (0 host-reset ack, 1 out-of-band ack, 2 suspend ack, 3 boot-done, 4 boot-status) and `tx_level`, the new level. Changes that happen on the same clock are reported on consecutive cycles, lowest id first.
- R10: Events with an id other than 0, 1 or 2 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| g3_rst | input | 1 | Synchronous G3 reset, active high |
| vw_evt_valid | input | 1 | A decoded incoming wire event is present |
| vw_evt_id | input | EVT_ID_W | Incoming wire number (0 host warn, 1 out-of-band warn, 2 suspend warn) |
| vw_evt_level | input | 1 | New level of the incoming wire |
| fw_boot_done | input | 1 | Pulse from firmware when booting has finished |
| fw_boot_ok | input | 1 | Image integrity result, sampled with fw_boot_done |
| q_empty | input | NCH | Upstream queue of each channel is empty |
| q_busy | input | NCH | An upstream request of each channel is in flight |
| up_req | input | NCH | New upstream request per channel |
| up_accept | output | NCH | Request taken per channel |
| cfg_we | input | 1 | Channel-enable register write strobe |
| cfg_wdata | input | NCH | Channel-enable write data |
| ch_en | output | NCH | Channel enables |
| quiesce | output | NCH | Per-channel request to stop and drain |
| host_rst_ack | output | 1 | Host-reset acknowledge wire |
| oob_rst_ack | output | 1 | Out-of-band reset acknowledge wire |
| sus_ack | output | 1 | Suspend acknowledge wire |
| boot_done | output | 1 | Boot-done wire |
| boot_status | output | 1 | Boot-status wire |
| tx_valid | output | 1 | Outgoing wire event present |
| tx_id | output | 3 | Outgoing wire number |
| tx_level | output | 1 | Outgoing wire level |

## Verification
The handshake is first run against a queue that is still filling. The queue then becomes empty while a request is still in flight, and finally goes fully idle. This separates "empty" from "idle" and fixes the exact cycle at which the acknowledge may rise. A second warning that arrives while the acknowledge is high, and a suspend warning that waits on the flash queue alone, show that the restart path and the multi-channel drain mask each work. A boot report with the image good, a repeated report with the image bad, and a G3 reset followed by a bad-image boot show that the boot wires are latched and cleared. A scoreboard holds the expected wire events in order. It catches missing, extra, reordered or wrong-level events, including the lowest-id-first ordering when boot-done and boot-status change together.

// File: rtl/vwr_pkg.sv
package vwr_pkg;

    // channel numbering on the link
    localparam int unsigned CH_PERIPH = 0;
    localparam int unsigned CH_VWIRE  = 1;
    localparam int unsigned CH_OOB    = 2;
    localparam int unsigned CH_FLASH  = 3;

    // incoming warning wires, numbered as their event id
    localparam int unsigned WARN_HOST = 0;
    localparam int unsigned WARN_OOB  = 1;
    localparam int unsigned WARN_SUS  = 2;
    localparam int unsigned NUM_WARN  = 3;

    // outgoing wires, numbered as their report id (also report priority)
    localparam int unsigned TXW_HOST_ACK    = 0;
    localparam int unsigned TXW_OOB_ACK     = 1;
    localparam int unsigned TXW_SUS_ACK     = 2;
    localparam int unsigned TXW_BOOT_DONE   = 3;
    localparam int unsigned TXW_BOOT_STATUS = 4;
    localparam int unsigned NUM_TXW         = 5;
    localparam int unsigned TX_ID_W         = $clog2(NUM_TXW);

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_DRAIN = 2'd1,
        HS_ACKED = 2'd2
    } hs_state_e;

    // channels a warning must drain before it may be acknowledged
    function automatic logic [31:0] warn_chan_mask(int unsigned w);
        logic [31:0] m;
        case (w)
            WARN_HOST: m = 32'd1 << CH_PERIPH;
            WARN_OOB:  m = 32'd1 << CH_OOB;
            default:   m = ~(32'd1 << CH_VWIRE);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vwr_warn_fsm.sv
module vwr_warn_fsm
    import vwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic g3_rst,
    input  logic evt_hit,
    input  logic evt_level,
    input  logic chan_idle,
    output logic quiesce,
    output logic ack
);

    typedef struct packed {
        hs_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (g3_rst) begin
            fsm_d.st = HS_IDLE;
        end else if (evt_hit) begin
            // a raised warning always restarts the drain
            fsm_d.st = evt_level ? HS_DRAIN : HS_IDLE;
        end else if (fsm_q.st == HS_DRAIN && chan_idle) begin
            fsm_d.st = HS_ACKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: HS_IDLE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign quiesce = (fsm_q.st != HS_IDLE);
    assign ack     = (fsm_q.st == HS_ACKED);

endmodule

// File: rtl/vwr_tx_report.sv
module vwr_tx_report #(
    parameter int unsigned NW  = 5,
    parameter int unsigned IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           g3_rst,
    input  logic [NW-1:0]  wires,
    output logic           tx_valid,
    output logic [IDW-1:0] tx_id,
    output logic           tx_level
);

    typedef struct packed {
        logic [NW-1:0] last;
        logic [NW-1:0] pend;
    } rep_t;

    rep_t          rep_d, rep_q;
    logic          sel_found;
    logic [IDW-1:0] sel_idx;
    logic [NW-1:0] sel_clr;

    // lowest pending wire number goes out first
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < int'(NW); i++) begin
            if (rep_q.pend[i] && !sel_found) begin
                sel_found = 1'b1;
                sel_idx   = IDW'(i);
            end
        end
    end

    always_comb begin
        sel_clr = '0;
        if (sel_found) begin
            sel_clr[sel_idx] = 1'b1;
        end
        rep_d      = rep_q;
        rep_d.last = wires;
        rep_d.pend = (rep_q.pend & ~sel_clr) | (wires ^ rep_q.last);
        if (g3_rst) begin
            rep_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign tx_valid = sel_found;
    assign tx_id    = sel_idx;
    assign tx_level = rep_q.last[sel_idx];

endmodule

// File: rtl/vwr_responder.sv
module vwr_responder
    import vwr_pkg::*;
#(
    parameter int unsigned NCH      = 4,
    parameter int unsigned EVT_ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                g3_rst,
    input  logic                vw_evt_valid,
    input  logic [EVT_ID_W-1:0] vw_evt_id,
    input  logic                vw_evt_level,
    input  logic                fw_boot_done,
    input  logic                fw_boot_ok,
    input  logic [NCH-1:0]      q_empty,
    input  logic [NCH-1:0]      q_busy,
    input  logic [NCH-1:0]      up_req,
    output logic [NCH-1:0]      up_accept,
    input  logic                cfg_we,
    input  logic [NCH-1:0]      cfg_wdata,
    output logic [NCH-1:0]      ch_en,
    output logic [NCH-1:0]      quiesce,
    output logic                host_rst_ack,
    output logic                oob_rst_ack,
    output logic                sus_ack,
    output logic                boot_done,
    output logic                boot_status,
    output logic                tx_valid,
    output logic [TX_ID_W-1:0]  tx_id,
    output logic                tx_level
);

    typedef struct packed {
        logic [NCH-1:0] ch_en;
        logic           boot_done;
        logic           boot_status;
    } ctl_t;

    ctl_t                ctl_d, ctl_q;
    logic [NCH-1:0]      chan_idle;
    logic [NUM_WARN-1:0] warn_quiesce;
    logic [NUM_WARN-1:0] warn_ack;
    logic [NCH-1:0]      quiesce_c;
    logic [NUM_TXW-1:0]  tx_wires;

    assign chan_idle = q_empty & ~q_busy;

    // one handshake engine per warning wire
    for (genvar gw = 0; gw < NUM_WARN; gw++) begin : g_warn
        localparam logic [NCH-1:0] W_MASK = NCH'(warn_chan_mask(gw));
        logic hit;
        logic idle;
        assign hit  = vw_evt_valid && (vw_evt_id == EVT_ID_W'(gw));
        assign idle = &(chan_idle | ~W_MASK);
        vwr_warn_fsm i_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .g3_rst    (g3_rst),
            .evt_hit   (hit),
            .evt_level (vw_evt_level),
            .chan_idle (idle),
            .quiesce   (warn_quiesce[gw]),
            .ack       (warn_ack[gw])
        );
    end

    always_comb begin
        quiesce_c = '0;
        for (int w = 0; w < int'(NUM_WARN); w++) begin
            if (warn_quiesce[w]) begin
                quiesce_c = quiesce_c | NCH'(warn_chan_mask(w));
            end
        end
    end

    // channel enables and boot wires
    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we) begin
            ctl_d.ch_en = cfg_wdata;
        end
        if (fw_boot_done && !ctl_q.boot_done) begin
            ctl_d.boot_done   = 1'b1;
            ctl_d.boot_status = fw_boot_ok;
        end
        if (g3_rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        tx_wires                  = '0;
        tx_wires[TXW_HOST_ACK]    = warn_ack[WARN_HOST];
        tx_wires[TXW_OOB_ACK]     = warn_ack[WARN_OOB];
        tx_wires[TXW_SUS_ACK]     = warn_ack[WARN_SUS];
        tx_wires[TXW_BOOT_DONE]   = ctl_q.boot_done;
        tx_wires[TXW_BOOT_STATUS] = ctl_q.boot_status;
    end

    vwr_tx_report #(
        .NW  (NUM_TXW),
        .IDW (TX_ID_W)
    ) i_report (
        .clk      (clk),
        .rst_n    (rst_n),
        .g3_rst   (g3_rst),
        .wires    (tx_wires),
        .tx_valid (tx_valid),
        .tx_id    (tx_id),
        .tx_level (tx_level)
    );

    assign quiesce      = quiesce_c;
    assign ch_en        = ctl_q.ch_en;
    assign up_accept    = up_req & ctl_q.ch_en & ~quiesce_c;
    assign host_rst_ack = warn_ack[WARN_HOST];
    assign oob_rst_ack  = warn_ack[WARN_OOB];
    assign sus_ack      = warn_ack[WARN_SUS];
    assign boot_done    = ctl_q.boot_done;
    assign boot_status  = ctl_q.boot_status;

endmodule

// File: rtl/vwr_checker.sv
module vwr_checker
    import vwr_pkg::*;
#(
    parameter int unsigned NCH      = 4,
    parameter int unsigned EVT_ID_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                g3_rst,
    input logic                vw_evt_valid,
    input logic [EVT_ID_W-1:0] vw_evt_id,
    input logic                vw_evt_level,
    input logic [NCH-1:0]      q_empty,
    input logic [NCH-1:0]      q_busy,
    input logic                cfg_we,
    input logic [NCH-1:0]      cfg_wdata,
    input logic [NCH-1:0]      ch_en,
    input logic                host_rst_ack,
    input logic                oob_rst_ack,
    input logic                sus_ack,
    input logic                boot_done,
    input logic                boot_status,
    input logic                tx_valid,
    input logic [TX_ID_W-1:0]  tx_id
);

    AST_G3_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        g3_rst |=> (ch_en == '0 && !boot_done && !boot_status &&
                    !host_rst_ack && !oob_rst_ack && !sus_ack)); // R1

    AST_HOST_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rst_ack) |-> $past(q_empty[CH_PERIPH] && !q_busy[CH_PERIPH])); // R2

    AST_OOB_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oob_rst_ack) |-> $past(q_empty[CH_OOB] && !q_busy[CH_OOB])); // R3

    AST_HOST_WARN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (vw_evt_valid && vw_evt_id == EVT_ID_W'(WARN_HOST) && !vw_evt_level)
        |=> !host_rst_ack); // R5

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !g3_rst) |=> (ch_en == $past(cfg_wdata))); // R6

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !g3_rst) |=> (boot_done && $stable(boot_status))); // R8

    AST_TX_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_id < TX_ID_W'(NUM_TXW))); // R9

endmodule

bind vwr_responder vwr_checker #(
    .NCH      (NCH),
    .EVT_ID_W (EVT_ID_W)
) i_vwr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .g3_rst       (g3_rst),
    .vw_evt_valid (vw_evt_valid),
    .vw_evt_id    (vw_evt_id),
    .vw_evt_level (vw_evt_level),
    .q_empty      (q_empty),
    .q_busy       (q_busy),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .ch_en        (ch_en),
    .host_rst_ack (host_rst_ack),
    .oob_rst_ack  (oob_rst_ack),
    .sus_ack      (sus_ack),
    .boot_done    (boot_done),
    .boot_status  (boot_status),
    .tx_valid     (tx_valid),
    .tx_id        (tx_id)
);

// File: tb/test_vwr_responder.sv
`timescale 1ns/1ps
module test_vwr_responder;

    localparam int NCH      = 4;
    localparam int EVT_ID_W = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                g3_rst = 1'b0;
    logic                vw_evt_valid = 1'b0;
    logic [EVT_ID_W-1:0] vw_evt_id = '0;
    logic                vw_evt_level = 1'b0;
    logic                fw_boot_done = 1'b0;
    logic                fw_boot_ok = 1'b0;
    logic [NCH-1:0]      q_empty = '1;
    logic [NCH-1:0]      q_busy = '0;
    logic [NCH-1:0]      up_req = '1;
    logic [NCH-1:0]      up_accept;
    logic                cfg_we = 1'b0;
    logic [NCH-1:0]      cfg_wdata = '0;
    logic [NCH-1:0]      ch_en;
    logic [NCH-1:0]      quiesce;
    logic                host_rst_ack, oob_rst_ack, sus_ack;
    logic                boot_done, boot_status;
    logic                tx_valid;
    logic [2:0]          tx_id;
    logic                tx_level;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;
    logic [3:0] exp_q[$];

    always #2.5 clk = ~clk;

    vwr_responder #(.NCH(NCH), .EVT_ID_W(EVT_ID_W)) i_vwr_responder (
        .clk(clk), .rst_n(rst_n), .g3_rst(g3_rst),
        .vw_evt_valid(vw_evt_valid), .vw_evt_id(vw_evt_id), .vw_evt_level(vw_evt_level),
        .fw_boot_done(fw_boot_done), .fw_boot_ok(fw_boot_ok),
        .q_empty(q_empty), .q_busy(q_busy), .up_req(up_req), .up_accept(up_accept),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ch_en(ch_en), .quiesce(quiesce),
        .host_rst_ack(host_rst_ack), .oob_rst_ack(oob_rst_ack), .sus_ack(sus_ack),
        .boot_done(boot_done), .boot_status(boot_status),
        .tx_valid(tx_valid), .tx_id(tx_id), .tx_level(tx_level)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_evt(int id, bit lvl);
        vw_evt_valid = 1'b1;
        vw_evt_id    = EVT_ID_W'(id);
        vw_evt_level = lvl;
        tick();
        vw_evt_valid = 1'b0;
    endtask

    task automatic cfg_write(logic [NCH-1:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic boot(bit ok);
        fw_boot_done = 1'b1;
        fw_boot_ok   = ok;
        tick();
        fw_boot_done = 1'b0;
    endtask

    task automatic expect_evt(int id, bit lvl);
        exp_q.push_back({3'(id), lvl});
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // scoreboard monitor for outgoing wire events (R9)
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected event", {28'd0, tx_id, tx_level}, 32'hFFFF);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk("R9 event id/level", {28'd0, tx_id, tx_level}, {28'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R1 reset acks", {host_rst_ack, oob_rst_ack, sus_ack}, 0);
        chk("R1 reset boot", {boot_done, boot_status}, 0);
        chk("R1 reset ch_en", ch_en, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after reset quiesce", quiesce, 0);
        chk("R7 disabled rejects", up_accept, 0);

        cfg_write(4'b1111);
        chk("R6 enable write", ch_en, 4'b1111);
        chk("R7 accept enabled", up_accept, 4'b1111);

        // host reset warning against a queue that is still filling
        q_empty[0] = 1'b0;
        send_evt(0, 1);
        chk("R2 quiesce periph", quiesce, 4'b0001);
        chk("R7 quiesced rejects", up_accept, 4'b1110);
        chk("R2 no ack yet", host_rst_ack, 0);
        tick(3);
        chk("R2 no ack while filled", host_rst_ack, 0);
        q_empty[0] = 1'b1;
        q_busy[0]  = 1'b1;
        tick();
        chk("R2 no ack while in flight", host_rst_ack, 0);
        q_busy[0] = 1'b0;
        chk("R2 ack not early", host_rst_ack, 0);
        expect_evt(0, 1);
        tick();
        chk("R2 ack one clock after idle", host_rst_ack, 1);
        tick(4);

        cfg_write(4'b1110);
        chk("R6 master disables periph", ch_en, 4'b1110);
        chk("R7 other channels accept", up_accept, 4'b1110);

        expect_evt(0, 0);
        send_evt(0, 0);
        chk("R5 ack drops", host_rst_ack, 0);
        chk("R5 quiesce drops", quiesce, 0);
        chk("R7 disabled still rejects", up_accept, 4'b1110);
        cfg_write(4'b1111);
        chk("R7 re-enabled accepts", up_accept, 4'b1111);
        tick(4);

        // out-of-band warning with an idle queue
        send_evt(1, 1);
        chk("R3 quiesce oob", quiesce, 4'b0100);
        chk("R3 no ack yet", oob_rst_ack, 0);
        expect_evt(1, 1);
        tick();
        chk("R3 ack", oob_rst_ack, 1);
        tick(4);

        // repeated warning restarts the handshake
        expect_evt(1, 0);
        expect_evt(1, 1);
        send_evt(1, 1);
        chk("R5 restart drops ack", oob_rst_ack, 0);
        tick();
        chk("R5 restart re-acks", oob_rst_ack, 1);
        tick(4);
        expect_evt(1, 0);
        send_evt(1, 0);
        chk("R5 oob ack drops", oob_rst_ack, 0);
        tick(4);

        // suspend waits on the flash queue
        q_empty[3] = 1'b0;
        send_evt(2, 1);
        chk("R4 suspend quiesce mask", quiesce, 4'b1101);
        tick(2);
        chk("R4 no ack while flash busy", sus_ack, 0);
        q_empty[3] = 1'b1;
        expect_evt(2, 1);
        tick();
        chk("R4 suspend ack", sus_ack, 1);
        tick(4);
        expect_evt(2, 0);
        send_evt(2, 0);
        chk("R5 suspend ack drops", sus_ack, 0);
        tick(4);

        // unknown event id
        send_evt(5, 1);
        tick(3);
        chk("R10 unknown id quiesce", quiesce, 0);
        chk("R10 unknown id acks", {host_rst_ack, oob_rst_ack, sus_ack}, 0);

        // boot wires
        expect_evt(3, 1);
        expect_evt(4, 1);
        boot(1'b1);
        chk("R8 boot done", boot_done, 1);
        chk("R8 boot status good", boot_status, 1);
        tick(4);
        boot(1'b0);
        tick();
        chk("R8 status held", boot_status, 1);
        tick(4);

        // G3 reset
        expect_evt(0, 1);
        send_evt(0, 1);
        tick(5);
        g3_rst = 1'b1;
        tick();
        g3_rst = 1'b0;
        chk("R1 g3 acks", {host_rst_ack, oob_rst_ack, sus_ack}, 0);
        chk("R1 g3 boot", {boot_done, boot_status}, 0);
        chk("R1 g3 ch_en", ch_en, 0);
        chk("R1 g3 quiesce", quiesce, 0);
        chk("R7 g3 rejects", up_accept, 0);
        tick(5);
        expect_evt(3, 1);
        boot(1'b0);
        chk("R8 boot after g3", {boot_done, boot_status}, 2'b10);
        tick(6);
        chk("R9 all events seen", exp_q.size(), 0);
        finish_run();
    end

endmodule